// File: doc/BRIEF.md
# Converter Result Multi-Format Output Port

This block is the digital output side of a 12-bit sampling converter. A conversion is requested either by a rising edge on an asynchronous start input or, while that input rests low, by chip-select going low. The block models the conversion core as a fixed number of clocks. During that time it holds an active-low busy flag. When the count ends it captures the sample presented by the core into a single result register.

A two-bit format select decides how that result leaves the block. In parallel format a read returns all twelve bits at once. In either byte format a read returns one byte, picked by a high-byte select input. The upper byte is zero-padded. In these byte formats the block also sends each new result as a framed serial stream: an active-low strobe, a data line and a serial clock. The serial clock is shown only during the frame (gated format) or all the time (continuous format). The bus outputs come with drive enables that a pad ring turns into three-state pins.

Top module: `adc_result_port`

## Requirements
- R1: `cnv_start` passes through a two-stage synchronizer. Its rising edge starts a conversion: `busy_n` goes low at the third rising clock edge that samples `cnv_start` high.
- R2: While the synchronized `cnv_start` is low, a falling `cs_n` starts a conversion. A falling edge means high at one clock edge and low at the next. `busy_n` goes low at that second edge.
- R3: `busy_n` stays low for exactly CONV_CYCLES clocks. Start requests that arrive while busy are ignored.
- R4: At the edge where `busy_n` returns high, the result register loads `sample_in`. Reads return that value until the next conversion ends, whatever `sample_in` does meanwhile.
- R5: The bus drives only while `cs_n` and `rd_n` are both low. Otherwise both enables are 0 and `bus_data` is 0.
- R6: `fmt_sel` encodes 00 parallel, 01 gated serial, 10 continuous serial, 11 parallel. In parallel format a read enables all 12 bits with the full result, and `hi_byte_sel` has no effect.
- R7: In the two serial formats a read enables only bits 7:0 (`bus_oe_hi`=0, bits 11:8 are 0). With `hi_byte_sel`=0 they carry result[7:0]. With `hi_byte_sel`=1 they carry {4'b0000, result[11:8]}.
- R8: In the serial formats, a frame starts at the first internal serial-clock rise after a load. `ser_strb_n` is low for exactly 12 serial-clock periods. `ser_dat` carries the result MSB first, changes on rising serial-clock edges and is stable at falling ones.
- R9: The internal serial clock starts low at reset and toggles every SCLK_HALF clocks, first rising at the SCLK_HALF-th edge after reset. In continuous format `ser_clk` follows it at all times.
- R10: In gated format `ser_clk` is low outside a frame and gives exactly 12 pulses per frame.
- R11: In parallel format no frame is launched, and the outputs sit at `ser_strb_n`=1, `ser_clk`=0, `ser_dat`=0.
- R12: A result loaded while a frame is running restarts the frame from its MSB at the next serial-clock rise.
- R13: Synchronous active-high reset gives `busy_n`=1, `ser_strb_n`=1, `ser_clk`=0 and a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 2 | Output format select |
| cnv_start | input | 1 | Asynchronous conversion start, rising edge |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| hi_byte_sel | input | 1 | Byte read selects upper byte when high |
| sample_in | input | RES_W | Sample offered by the conversion core |
| busy_n | output | 1 | Conversion in progress, active low |
| bus_data | output | RES_W | Read data |
| bus_oe_hi | output | 1 | Drive enable for bits 11:8 |
| bus_oe_lo | output | 1 | Drive enable for bits 7:0 |
| ser_strb_n | output | 1 | Serial frame strobe, active low |
| ser_clk | output | 1 | Serial clock |
| ser_dat | output | 1 | Serial data |

## Verification
The bench builds the block with CONV_CYCLES=5 and SCLK_HALF=3. With these values a conversion is far shorter than a 72-clock frame, so a second result can land in the middle of a running frame, which exercises the restart. The odd half-period makes loads fall at different phases of the serial clock. A short conversion also lets the bench throw start edges at a busy converter and then confirm at the ports that nothing moved.

// File: rtl/adcport_pkg.sv
package adcport_pkg;

    typedef enum logic [1:0] {
        FMT_PAR     = 2'b00,
        FMT_GATED   = 2'b01,
        FMT_CONT    = 2'b10,
        FMT_PAR_ALT = 2'b11
    } fmt_e;

    typedef struct packed {
        logic strb_n;
        logic clk;
        logic dat;
    } ser_t;

    typedef struct packed {
        logic oe_hi;
        logic oe_lo;
    } drive_t;

    function automatic logic is_par(fmt_e f);
        return (f == FMT_PAR) || (f == FMT_PAR_ALT);
    endfunction

endpackage

// File: rtl/adcport_sync.sv
module adcport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~last;

    assert_rise_single_R1: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/adcport_conv.sv
module adcport_conv #(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_rise,
    input  logic             start_level,
    input  logic             cs_n,
    input  logic [RES_W-1:0] sample_in,
    output logic             busy,
    output logic             load,
    output logic [RES_W-1:0] result
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          cs_q;
    logic          req;

    assign req  = start_rise | (~start_level & cs_q & ~cs_n);
    assign load = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            result <= '0;
            cs_q   <= 1'b1;
        end else begin
            cs_q <= cs_n;
            if (busy) begin
                if (cnt == '0) begin
                    busy   <= 1'b0;
                    result <= sample_in;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (req) begin
                busy <= 1'b1;
                cnt  <= CW'(CONV_CYCLES - 1);
            end
        end
    end

    assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> (busy && cnt == CW'($past(cnt) - 1'b1)));

    assert_load_on_release_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (result == $past(sample_in)));

endmodule

// File: rtl/adcport_serial.sv
module adcport_serial
    import adcport_pkg::*;
#(
    parameter int RES_W     = 12,
    parameter int SCLK_HALF = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  fmt_e             fmt,
    input  logic             load,
    input  logic [RES_W-1:0] result,
    output ser_t             ser
);
    localparam int DW = $clog2(SCLK_HALF + 1);
    localparam int IW = $clog2(RES_W);

    logic [DW-1:0]    div;
    logic             sclk_int;
    logic             rise_ev;
    logic             pending;
    logic             active;
    logic [IW-1:0]    idx;
    logic [RES_W-1:0] word;
    logic             bit_val;

    assign rise_ev = (div == DW'(SCLK_HALF - 1)) && !sclk_int;
    assign bit_val = word[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            div      <= '0;
            sclk_int <= 1'b0;
            pending  <= 1'b0;
            active   <= 1'b0;
            idx      <= '0;
            word     <= '0;
        end else begin
            if (div == DW'(SCLK_HALF - 1)) begin
                div      <= '0;
                sclk_int <= ~sclk_int;
            end else begin
                div <= div + 1'b1;
            end

            if (rise_ev) begin
                if (pending) begin
                    active <= 1'b1;
                    idx    <= IW'(RES_W - 1);
                    word   <= result;
                end else if (active) begin
                    if (idx == '0) active <= 1'b0;
                    else           idx    <= idx - 1'b1;
                end
            end

            if (load && !is_par(fmt)) pending <= 1'b1;
            else if (rise_ev)         pending <= 1'b0;
        end
    end

    always_comb begin
        ser = '{strb_n: 1'b1, clk: 1'b0, dat: 1'b0};
        if (!is_par(fmt)) begin
            ser.strb_n = ~active;
            ser.dat    = active & bit_val;
            ser.clk    = (fmt == FMT_CONT) ? sclk_int : (sclk_int & active);
        end
    end

    assert_data_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (active && $fell(sclk_int)) |-> $stable(bit_val));

    assert_frame_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (idx == IW'(RES_W - 1) && sclk_int));

    assert_frame_end_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(idx) == '0 && sclk_int));

endmodule

// File: rtl/adcport_bus.sv
module adcport_bus
    import adcport_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8
) (
    input  fmt_e             fmt,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             hi_sel,
    input  logic [RES_W-1:0] result,
    output drive_t           drv,
    output logic [RES_W-1:0] data
);
    logic rd_en;
    assign rd_en = ~cs_n & ~rd_n;

    always_comb begin
        drv  = '{oe_hi: 1'b0, oe_lo: 1'b0};
        data = '0;
        if (rd_en) begin
            if (is_par(fmt)) begin
                drv  = '{oe_hi: 1'b1, oe_lo: 1'b1};
                data = result;
            end else begin
                drv.oe_lo = 1'b1;
                data[BYTE_W-1:0] = hi_sel ? BYTE_W'(result[RES_W-1:BYTE_W])
                                          : result[BYTE_W-1:0];
            end
        end
    end

    always_comb begin
        assert_idle_quiet_R5: assert ((cs_n || rd_n) ? (drv == '0 && data == '0) : 1'b1);
    end

endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
    import adcport_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 20,
    parameter int SCLK_HALF   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       fmt_sel,
    input  logic             cnv_start,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             hi_byte_sel,
    input  logic [RES_W-1:0] sample_in,
    output logic             busy_n,
    output logic [RES_W-1:0] bus_data,
    output logic             bus_oe_hi,
    output logic             bus_oe_lo,
    output logic             ser_strb_n,
    output logic             ser_clk,
    output logic             ser_dat
);
    localparam int BYTE_W = 8;

    fmt_e             fmt;
    logic             start_level;
    logic             start_rise;
    logic             busy;
    logic             load;
    logic [RES_W-1:0] result;
    ser_t             ser;
    drive_t           drv;

    assign fmt = fmt_e'(fmt_sel);

    adcport_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cnv_start),
        .level    (start_level),
        .rise     (start_rise)
    );

    adcport_conv #(.RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk         (clk),
        .rst         (rst),
        .start_rise  (start_rise),
        .start_level (start_level),
        .cs_n        (cs_n),
        .sample_in   (sample_in),
        .busy        (busy),
        .load        (load),
        .result      (result)
    );

    adcport_serial #(.RES_W(RES_W), .SCLK_HALF(SCLK_HALF)) u_serial (
        .clk    (clk),
        .rst    (rst),
        .fmt    (fmt),
        .load   (load),
        .result (result),
        .ser    (ser)
    );

    adcport_bus #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_bus (
        .fmt    (fmt),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .hi_sel (hi_byte_sel),
        .result (result),
        .drv    (drv),
        .data   (bus_data)
    );

    assign busy_n     = ~busy;
    assign bus_oe_hi  = drv.oe_hi;
    assign bus_oe_lo  = drv.oe_lo;
    assign ser_strb_n = ser.strb_n;
    assign ser_clk    = ser.clk;
    assign ser_dat    = ser.dat;

    assert_byte_hi_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !is_par(fmt) |-> !bus_oe_hi);

    assert_par_no_frame_R11: assert property (@(posedge clk) disable iff (rst)
        is_par(fmt) |-> (ser_strb_n && !ser_clk));

endmodule

// File: tb/tb_adc_result_port.sv
module tb_adc_result_port;
    localparam int W    = 12;
    localparam int CONV = 5;
    localparam int HALF = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    fmt_sel = 2'b00;
    logic          cnv_start = 1'b0;
    logic          cs_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          hi_byte_sel = 1'b0;
    logic [W-1:0]  sample_in = '0;
    logic          busy_n, bus_oe_hi, bus_oe_lo, ser_strb_n, ser_clk, ser_dat;
    logic [W-1:0]  bus_data;

    adc_result_port #(.RES_W(W), .CONV_CYCLES(CONV), .SCLK_HALF(HALF)) dut (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .cnv_start(cnv_start),
        .cs_n(cs_n), .rd_n(rd_n), .hi_byte_sel(hi_byte_sel), .sample_in(sample_in),
        .busy_n(busy_n), .bus_data(bus_data), .bus_oe_hi(bus_oe_hi),
        .bus_oe_lo(bus_oe_lo), .ser_strb_n(ser_strb_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R13";
    bit    started  = 1'b0;
    bit    done     = 1'b0;

    // behavioural reference state
    int       ncyc = 0;
    bit       s1 = 0, s2 = 0, s2d = 0, csq = 1;
    int       left = 0;
    logic [W-1:0] res = '0;
    bit       pend = 0, act = 0;
    int       bitn = 0;
    logic [W-1:0] word = '0;

    function automatic bit serial_fmt(logic [1:0] f);
        return (f == 2'b01) || (f == 2'b10);
    endfunction

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            ncyc = 0; s1 = 0; s2 = 0; s2d = 0; csq = 1;
            left = 0; res = '0; pend = 0; act = 0; bitn = 0; word = '0;
        end else begin
            bit rise, ld, st;
            ncyc++;
            rise = (ncyc % (2*HALF)) == HALF;
            if (rise) begin
                if (pend) begin act = 1; bitn = W-1; word = res; end
                else if (act) begin
                    if (bitn == 0) act = 0; else bitn--;
                end
            end
            ld = 0;
            st = (s2 && !s2d) || (!s2 && csq && !cs_n);
            if (left > 0) begin
                left--;
                if (left == 0) begin ld = 1; res = sample_in; end
            end else if (st) left = CONV;
            if (ld && serial_fmt(fmt_sel)) pend = 1;
            else if (rise) pend = 0;
            s2d = s2; s2 = s1; s1 = cnv_start; csq = cs_n;
        end
    end

    task automatic chk(string what, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", phase, what, got, exp, ncyc);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            bit sclk_m, rd;
            logic [W-1:0] ed;
            sclk_m = ((ncyc / HALF) % 2) == 1;
            chk("busy_n", 16'(busy_n), 16'(left == 0));
            rd = !cs_n && !rd_n;
            ed = '0;
            if (rd) begin
                if (!serial_fmt(fmt_sel)) ed = res;
                else ed = hi_byte_sel ? W'(res[W-1:8]) : W'(res[7:0]);
            end
            chk("bus_data", 16'(bus_data), 16'(ed));
            chk("bus_oe_hi", 16'(bus_oe_hi), 16'(rd && !serial_fmt(fmt_sel)));
            chk("bus_oe_lo", 16'(bus_oe_lo), 16'(rd));
            if (!serial_fmt(fmt_sel)) begin
                chk("ser_strb_n", 16'(ser_strb_n), 16'd1);
                chk("ser_clk", 16'(ser_clk), 16'd0);
                chk("ser_dat", 16'(ser_dat), 16'd0);
            end else begin
                chk("ser_strb_n", 16'(ser_strb_n), 16'(!act));
                chk("ser_clk", 16'(ser_clk),
                    16'((fmt_sel == 2'b10) ? sclk_m : (sclk_m && act)));
                chk("ser_dat", 16'(ser_dat), 16'(act ? word[bitn] : 1'b0));
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #5; end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R13: reset state
        step(4);
        rst = 1'b0;
        step(3);
        // R1: synchronized rising edge starts a conversion (parallel format)
        phase = "R1"; sample_in = 12'hA5C; cnv_start = 1'b1;
        step(12);
        // R6: parallel read, high-byte select ignored
        phase = "R6"; cs_n = 1'b0; rd_n = 1'b0;
        step(2); hi_byte_sel = 1'b1; step(2); hi_byte_sel = 1'b0;
        cs_n = 1'b1; rd_n = 1'b1; step(2);
        fmt_sel = 2'b11; cs_n = 1'b0; rd_n = 1'b0; hi_byte_sel = 1'b1; step(2);
        cs_n = 1'b1; rd_n = 1'b1; hi_byte_sel = 1'b0; fmt_sel = 2'b00;
        // R4: result unaffected by later sample_in changes
        phase = "R4"; sample_in = 12'h111; step(2);
        cs_n = 1'b0; rd_n = 1'b0; step(2); cs_n = 1'b1; rd_n = 1'b1; step(2);
        // R5: only one of cs_n / rd_n low gives no drive
        phase = "R5"; cs_n = 1'b0; step(2); cs_n = 1'b1; rd_n = 1'b0; step(2); rd_n = 1'b1;
        // R10/R8/R7: gated format frame, byte reads
        phase = "R10"; fmt_sel = 2'b01; cnv_start = 1'b0; step(4);
        sample_in = 12'h3E7; cnv_start = 1'b1; step(12);
        phase = "R7"; cs_n = 1'b0; rd_n = 1'b0; step(2); hi_byte_sel = 1'b1; step(2);
        cs_n = 1'b1; rd_n = 1'b1; hi_byte_sel = 1'b0;
        phase = "R8"; step(90);
        // R2/R3: chip-select start with start input low, edges while busy ignored
        phase = "R2"; sample_in = 12'h81F; cnv_start = 1'b0; step(4);
        cs_n = 1'b0; step(1); cs_n = 1'b1; step(1);
        phase = "R3"; cnv_start = 1'b1; step(1); cs_n = 1'b0; step(1); cs_n = 1'b1;
        step(10); sample_in = 12'h000; step(80);
        // R9: continuous serial clock
        phase = "R9"; fmt_sel = 2'b10; cnv_start = 1'b0; step(4);
        sample_in = 12'hC36; cnv_start = 1'b1; step(90);
        // R12: second result lands mid-frame in gated format
        phase = "R12"; fmt_sel = 2'b01; cnv_start = 1'b0; step(4);
        sample_in = 12'h5A9; cnv_start = 1'b1; step(30);
        cnv_start = 1'b0; step(4); sample_in = 12'hF06; cnv_start = 1'b1; step(100);
        // R11: parallel format launches no frame
        phase = "R11"; fmt_sel = 2'b00; cnv_start = 1'b0; step(4);
        sample_in = 12'h7C1; cnv_start = 1'b1; step(80);
        // R13: reset again mid-operation
        phase = "R13"; cnv_start = 1'b0; fmt_sel = 2'b10; step(4);
        cnv_start = 1'b1; step(4); rst = 1'b1; step(3); rst = 1'b0; step(5);
        finish_run();
    end
endmodule